// File: doc/BRIEF.md
# Configurable PLD Output Macrocell

This block is one output cell of a sum-of-products programmable logic device. It receives the raw product terms for its pin from the AND array. It forms the OR of those terms and applies a programmable output polarity. Four configuration bits then choose the cell's mode: a clocked output, an always-driven combinational output, a combinational pin with an enable driven by a product term, or a pure input. The cell returns a feedback bit to the array. Two of the configuration bits are shared by every cell of the device and two belong to this cell alone.

The register has an asynchronous power-up reset. It can also be loaded directly from the pad for test. A parameter selects the cell variant. The plain variant suits inner cells. The edge variant suits the outermost cells, whose neighbours are the clock and enable pins. The third variant suits the cells that carry no feedback when they act as a dedicated combinational output.

Top module: `plmc_cell`

## Requirements
- R1: With `glb_noreg=0`, `glb_mode=1`, `loc_sel=0` (clocked mode), the cell samples the polarity-adjusted OR of all terms on each rising clock edge. `pad_out` and `fb` both show the stored value from the following cycle.
- R2: In clocked mode, `pad_oe` equals `out_en`.
- R3: With `loc_sel=1` and `glb_mode=1` (either value of `glb_noreg`), the cell is a combinational pin. `pad_oe` follows the top term `pterm[N_TERMS-1]`. `pad_out` uses the OR of the remaining terms. For plain cells, `fb` is `pad_in`.
- R4: With `glb_noreg=1`, `glb_mode=0`, `loc_sel=0`, `pad_oe` is always 1 and `pad_out` uses the OR of all terms. For plain cells, `fb` is `pad_in`.
- R5: With `glb_noreg=1`, `glb_mode=0`, `loc_sel=1` (input mode), `pad_oe` is 0 and `fb` is `adj_in`.
- R6: `loc_pol=1` makes the combinational output active high (`pad_out` = OR). `loc_pol=0` makes it active low (`pad_out` = inverted OR).
- R7: The codes {glb_noreg,glb_mode,loc_sel} = 000, 001 and 110 behave as input mode: `pad_oe` is 0 and `fb` is `adj_in`.
- R8: While `rst_n` is low, the register is cleared and `pad_out` reads 1 in clocked mode under either polarity.
- R9: When `preload` is 1 at a rising edge, the register takes `pad_in` instead of the terms, and clocked-mode `pad_out` then equals that `pad_in`.
- R10: In the edge variant (`CELL_KIND=1`), `glb_noreg` steers the feedback of the combinational pin mode. Code 111 returns `adj_in` and code 011 returns `pad_in`.
- R11: In the no-feedback variant (`CELL_KIND=2`), `fb` is 0 in the always-driven combinational mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock, rising edge |
| rst_n | input | 1 | Asynchronous power-up reset, active low |
| glb_noreg | input | 1 | Device-wide bit: 1 = no registers used |
| glb_mode | input | 1 | Device-wide mode bit |
| loc_sel | input | 1 | Per-cell mode bit |
| loc_pol | input | 1 | Per-cell polarity: 1 = active high |
| pterm | input | N_TERMS | Product terms from the AND array |
| out_en | input | 1 | Global output enable pin, active high |
| preload | input | 1 | Test strobe: load register from pad |
| pad_in | input | 1 | Value seen at this cell's pin |
| adj_in | input | 1 | Value seen at the neighbouring pin |
| pad_out | output | 1 | Value driven to the pin |
| pad_oe | output | 1 | Pin driver enable |
| fb | output | 1 | Feedback bit to the array |

## Verification
The assertions assume that the four configuration bits stay constant over a clock cycle and change only between cycles. An assertion that spans an edge is therefore qualified on the mode holding on both sides of that edge. The assertions also treat `pad_in` as an independent input, not as a loopback of `pad_out`. The bench changes configuration only at falling edges between test phases. It drives `pad_in` and `adj_in` from its own random values, so pad contention never arises, and it samples every output at the falling edge.

// File: rtl/plmc_pkg.sv
package plmc_pkg;

   typedef enum logic [1:0] {
      MD_REG   = 2'd0,
      MD_CIO   = 2'd1,
      MD_COMB  = 2'd2,
      MD_INPUT = 2'd3
   } cell_mode_e;

   localparam int KIND_PLAIN = 0;
   localparam int KIND_EDGE  = 1;
   localparam int KIND_NOFB  = 2;

   function automatic cell_mode_e decode_mode(input logic noreg, input logic gmode,
                                              input logic sel);
      cell_mode_e m;
      case ({noreg, gmode, sel})
         3'b010:          m = MD_REG;
         3'b011, 3'b111:  m = MD_CIO;
         3'b100:          m = MD_COMB;
         default:         m = MD_INPUT;
      endcase
      return m;
   endfunction

endpackage

// File: rtl/plmc_sum.sv
module plmc_sum #(
   parameter int N_TERMS = 8
) (
   input  logic [N_TERMS-1:0] pterm,
   output logic               full_sum,
   output logic               part_sum,
   output logic               en_term
);
   localparam int LOW_W = N_TERMS - 1;

   if (N_TERMS < 2) begin : g_bad_terms
      $error("plmc_sum: N_TERMS must be at least 2");
   end

   assign full_sum = |pterm;
   assign part_sum = |pterm[LOW_W-1:0];
   assign en_term  = pterm[N_TERMS-1];
endmodule

// File: rtl/plmc_store.sv
module plmc_store (
   input  logic clk,
   input  logic rst_n,
   input  logic d_val,
   input  logic preload,
   input  logic pad_in,
   output logic q_out
);
   // The flop holds the complement of the pin value, so a cleared flop reads as 1.
   logic q_n;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       q_n <= 1'b0;
      else if (preload) q_n <= ~pad_in;
      else              q_n <= ~d_val;
   end

   assign q_out = ~q_n;
endmodule

// File: rtl/plmc_route.sv
module plmc_route
   import plmc_pkg::*;
#(
   parameter int CELL_KIND = KIND_PLAIN
) (
   input  cell_mode_e mode,
   input  logic       pol_hi,
   input  logic       full_sum,
   input  logic       part_sum,
   input  logic       en_term,
   input  logic       out_en,
   input  logic       reg_val,
   input  logic       pad_in,
   input  logic       adj_in,
   input  logic       cio_from_adj,
   output logic       reg_d,
   output logic       pad_out,
   output logic       pad_oe,
   output logic       fb
);
   localparam bit COMB_HAS_FB = (CELL_KIND != KIND_NOFB);

   logic full_v, part_v;

   assign full_v = (full_sum == pol_hi);
   assign part_v = (part_sum == pol_hi);
   assign reg_d  = full_v;

   always_comb begin
      case (mode)
         MD_REG:  begin pad_out = reg_val; pad_oe = out_en;  end
         MD_CIO:  begin pad_out = part_v;  pad_oe = en_term; end
         MD_COMB: begin pad_out = full_v;  pad_oe = 1'b1;    end
         default: begin pad_out = full_v;  pad_oe = 1'b0;    end
      endcase
   end

   always_comb begin
      case (mode)
         MD_REG:  fb = reg_val;
         MD_CIO:  fb = cio_from_adj ? adj_in : pad_in;
         MD_COMB: fb = COMB_HAS_FB ? pad_in : 1'b0;
         default: fb = adj_in;
      endcase
   end
endmodule

// File: rtl/plmc_cell.sv
module plmc_cell
   import plmc_pkg::*;
#(
   parameter int N_TERMS   = 8,
   parameter int CELL_KIND = KIND_PLAIN
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               glb_noreg,
   input  logic               glb_mode,
   input  logic               loc_sel,
   input  logic               loc_pol,
   input  logic [N_TERMS-1:0] pterm,
   input  logic               out_en,
   input  logic               preload,
   input  logic               pad_in,
   input  logic               adj_in,
   output logic               pad_out,
   output logic               pad_oe,
   output logic               fb
);
   if (CELL_KIND < KIND_PLAIN || CELL_KIND > KIND_NOFB) begin : g_bad_kind
      $error("plmc_cell: CELL_KIND out of range");
   end

   cell_mode_e mode;
   logic full_sum, part_sum, en_term, reg_val, reg_d, cio_from_adj;

   assign mode = decode_mode(glb_noreg, glb_mode, loc_sel);

   if (CELL_KIND == KIND_EDGE) begin : g_edge_fb
      assign cio_from_adj = glb_noreg;
   end else begin : g_std_fb
      assign cio_from_adj = 1'b0;
   end

   plmc_sum #(.N_TERMS(N_TERMS)) u_sum (
      .pterm(pterm), .full_sum(full_sum), .part_sum(part_sum), .en_term(en_term)
   );

   plmc_store u_store (
      .clk(clk), .rst_n(rst_n), .d_val(reg_d), .preload(preload),
      .pad_in(pad_in), .q_out(reg_val)
   );

   plmc_route #(.CELL_KIND(CELL_KIND)) u_route (
      .mode(mode), .pol_hi(loc_pol), .full_sum(full_sum), .part_sum(part_sum),
      .en_term(en_term), .out_en(out_en), .reg_val(reg_val), .pad_in(pad_in),
      .adj_in(adj_in), .cio_from_adj(cio_from_adj), .reg_d(reg_d),
      .pad_out(pad_out), .pad_oe(pad_oe), .fb(fb)
   );

   // Port-level checks
   logic reg_cfg, off_cfg, comb_cfg;
   assign reg_cfg  = !glb_noreg && glb_mode && !loc_sel;
   assign comb_cfg = glb_noreg && !glb_mode && !loc_sel;
   assign off_cfg  = !reg_cfg && !comb_cfg && !(glb_mode && loc_sel);

   p_capture_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_cfg && !preload) |=> (!reg_cfg || pad_out == ($past(|pterm) == $past(loc_pol))));

   p_reg_enable_r2: assert property (@(posedge clk) disable iff (!rst_n)
      reg_cfg |-> (pad_oe == out_en));

   p_comb_on_r4: assert property (@(posedge clk) disable iff (!rst_n)
      comb_cfg |-> pad_oe);

   p_driver_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
      off_cfg |-> !pad_oe);

   p_reset_high_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(rst_n) && reg_cfg) |-> pad_out);

   p_preload_r9: assert property (@(posedge clk) disable iff (!rst_n)
      preload |=> (!reg_cfg || pad_out == $past(pad_in)));
endmodule

// File: tb/plmc_cell_test.sv
module plmc_cell_test;
   logic       clk = 1'b0;
   logic       rst_n;
   logic       g0, g1, l0, l1;
   logic [7:0] pterm;
   logic       out_en, preload, pad_in, adj_in;
   logic       po_a, oe_a, fb_a;
   logic       po_e, oe_e, fb_e;
   logic       po_n, oe_n, fb_n;

   int  total = 0;
   int  bad = 0;
   bit  done = 0;
   bit  ref_q = 1'b1;
   bit  prev_pre = 1'b0;

   always #5 clk = ~clk;

   plmc_cell #(.N_TERMS(8), .CELL_KIND(0)) uut (
      .clk(clk), .rst_n(rst_n), .glb_noreg(g0), .glb_mode(g1), .loc_sel(l0),
      .loc_pol(l1), .pterm(pterm), .out_en(out_en), .preload(preload),
      .pad_in(pad_in), .adj_in(adj_in), .pad_out(po_a), .pad_oe(oe_a), .fb(fb_a));

   plmc_cell #(.N_TERMS(8), .CELL_KIND(1)) uut_edge (
      .clk(clk), .rst_n(rst_n), .glb_noreg(g0), .glb_mode(g1), .loc_sel(l0),
      .loc_pol(l1), .pterm(pterm), .out_en(out_en), .preload(preload),
      .pad_in(pad_in), .adj_in(adj_in), .pad_out(po_e), .pad_oe(oe_e), .fb(fb_e));

   plmc_cell #(.N_TERMS(8), .CELL_KIND(2)) uut_nofb (
      .clk(clk), .rst_n(rst_n), .glb_noreg(g0), .glb_mode(g1), .loc_sel(l0),
      .loc_pol(l1), .pterm(pterm), .out_en(out_en), .preload(preload),
      .pad_in(pad_in), .adj_in(adj_in), .pad_out(po_n), .pad_oe(oe_n), .fb(fb_n));

   task automatic chk(input string req, input logic act, input logic exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0b expected=%0b (code=%b%b%b pol=%b t=%0t)",
                  req, act, exp, g0, g1, l0, l1, $time);
      end
   endtask

   // 0 clocked, 1 pin with term enable, 2 always driven, 3 input
   function automatic int mode_of(input logic a, input logic b, input logic c);
      if (!a && b && !c) return 0;
      if (b && c)        return 1;
      if (a && !b && !c) return 2;
      return 3;
   endfunction

   task automatic check_all();
      int    m = mode_of(g0, g1, l0);
      string in_tag = ({g0, g1, l0} == 3'b101) ? "R5" : "R7";
      logic  e_oe, e_out, e_fb;
      case (m)
         0: begin e_oe = out_en;   e_out = ref_q;               e_fb = ref_q;  end
         1: begin e_oe = pterm[7]; e_out = (|pterm[6:0]) == l1; e_fb = pad_in; end
         2: begin e_oe = 1'b1;     e_out = (|pterm) == l1;      e_fb = pad_in; end
         default: begin e_oe = 1'b0; e_out = 1'b0;              e_fb = adj_in; end
      endcase
      case (m)
         0: begin chk("R2", oe_a, e_oe); chk(prev_pre ? "R9" : "R1", po_a, e_out);
                  chk("R1", fb_a, e_fb); end
         1: begin chk("R3", oe_a, e_oe); chk("R6", po_a, e_out); chk("R3", fb_a, e_fb); end
         2: begin chk("R4", oe_a, e_oe); chk("R6", po_a, e_out); chk("R4", fb_a, e_fb); end
         default: begin chk(in_tag, oe_a, e_oe); chk(in_tag, fb_a, e_fb); end
      endcase
      // edge variant: feedback in pin mode chosen by glb_noreg
      chk("R10", fb_e, (m == 1 && g0) ? adj_in : e_fb);
      // no-feedback variant: silent in always-driven mode
      chk("R11", fb_n, (m == 2) ? 1'b0 : e_fb);
   endtask

   task automatic step();
      @(posedge clk);
      if (!rst_n)       ref_q = 1'b1;
      else if (preload) ref_q = pad_in;
      else              ref_q = ((|pterm) == l1);
      prev_pre = preload;
      @(negedge clk);
      check_all();
   endtask

   task automatic drive(input bit allow_pre);
      int sel = $urandom_range(0, 3);
      case (sel)
         0: pterm = 8'h00;
         1: pterm = 8'h80;
         default: pterm = 8'($urandom_range(0, 255));
      endcase
      out_en  = 1'($urandom_range(0, 1));
      pad_in  = 1'($urandom_range(0, 1));
      adj_in  = 1'($urandom_range(0, 1));
      preload = allow_pre && ($urandom_range(0, 3) == 0);
   endtask

   initial begin
      rst_n = 1'b0; g0 = 1'b0; g1 = 1'b1; l0 = 1'b0; l1 = 1'b0;
      pterm = 8'h00; out_en = 1'b1; preload = 1'b0; pad_in = 1'b0; adj_in = 1'b0;
      repeat (2) @(negedge clk);
      chk("R8", po_a, 1'b1);
      l1 = 1'b1;
      #1 chk("R8", po_a, 1'b1);
      l1 = 1'b0;
      rst_n = 1'b1;
      #1 chk("R8", po_a, 1'b1);

      // preload wins over an all-ones term vector
      @(negedge clk);
      pterm = 8'hFF; l1 = 1'b1; pad_in = 1'b0; preload = 1'b1;
      step();
      chk("R9", po_a, 1'b0);
      preload = 1'b0;
      step();
      chk("R1", po_a, 1'b1);

      for (int c = 0; c < 8; c++) begin
         for (int p = 0; p < 2; p++) begin
            {g0, g1, l0} = 3'(c);
            l1 = 1'(p);
            drive(1'b0);
            step();
            for (int k = 0; k < 24; k++) begin
               drive(c == 2);
               step();
            end
         end
      end

      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #200000;
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule